// File: doc/BRIEF.md
# Paired-Entry Page Table Refill Walker

The block is started when a memory reference misses in the hardware translation buffer. It takes the access flags and the 18-bit virtual address of the failed reference. From the user flag and the top address bit, it picks one of four table base addresses. It adds a six-bit page-pair index to that base and reads the table word from memory. Each table word holds two 18-bit software entries. The walker picks one entry and decodes its two-bit access code.

If the code allows the access, the walker writes the table word back with the chosen entry's age bit cleared. It then loads two hardware translations, one for the even and one for the odd virtual page of the pair. If the code forbids the access, the walker reports a fault together with a fail word and does not touch memory again. The block has one memory port, and that port carries one access at a time.

Top module: `pgw_walker`

## Requirements
- R1: The table address is the selected base plus the index `vaddr[16:11]`, zero-extended. The base is chosen as follows:
  - user with `vaddr[17]`=0: `base_ulo`
  - user with `vaddr[17]`=1: `base_uhi`
  - exec with `vaddr[17]`=1: `base_ehi`
  - exec with `vaddr[17]`=0: `base_elo`
- R2: When `vaddr[10]`=1, the entry used is the low half of the table word (bits 17:0). Otherwise the high half (bits 35:18) is used. The fields of an entry are: bits 17:16 access code, bit 13 age, bit 12 cache, bits 9:0 physical page-pair number.
- R3: Access code 00 ends the walk with `done` and `fault` high. There is no write-back and no translation load.
- R4: A write or a write-test reference counts as a write. With code 01 or 10, a read loads translations without write permission, and a write ends in a fault instead. Every fault presents `fail_word` = {user, write, access field, vaddr} in bits 21, 20, 19:18 and 17:0. The access field is 1 for code 01, 2 for code 10 and 0 for code 00.
- R5: Code 11 loads translations with write permission, for reads and for writes alike.
- R6: On success, the table word is written back to the same address before any translation load. The only change is that the chosen entry's age bit is cleared. All other bits are preserved.
- R7: `tlb_entry` has the following layout:
  - bit 17: valid, always 1
  - bit 14: write permission
  - bit 13: the entry's cache bit
  - bits 10:1: the page-pair number
  - bit 0: 0 for the even load, 1 for the odd load
  - all other bits: 0
- R8: A successful walk gives two consecutive `tlb_load` cycles: the even page first, `tlb_vpage`={vaddr[17:10],0}, then the odd page, with the last bit 1. The next cycle gives `done` with `fault` low.
- R9: `mem_req` stays high with a stable address and direction until `mem_ack`. Only one access is in flight at a time.
- R10: A request that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `mem_req`, `tlb_load` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | start a walk (taken when idle) |
| req_user | input | 1 | reference was in user mode |
| req_write | input | 1 | reference was a write |
| req_wtest | input | 1 | reference was a write test |
| req_vaddr | input | 18 | failing virtual address |
| base_ulo | input | 20 | table base, user low half |
| base_uhi | input | 20 | table base, user high half |
| base_ehi | input | 20 | table base, exec high half |
| base_elo | input | 20 | table base, exec low half |
| busy | output | 1 | walk in progress |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | physical word address |
| mem_wdata | output | 36 | write-back data |
| mem_ack | input | 1 | access complete (read data valid) |
| mem_rdata | input | 36 | read data |
| tlb_load | output | 1 | load one translation |
| tlb_vpage | output | 9 | virtual page being loaded |
| tlb_entry | output | 18 | hardware translation entry |
| done | output | 1 | walk finished (one cycle) |
| fault | output | 1 | walk ended in a fault (valid with done) |
| fail_word | output | 22 | fault description (valid with done and fault) |

## Verification
The bench tries every combination of the following:
- all four access codes
- both privilege modes
- both address halves
- both word halves
- a plain read, a write, and a write test

In each walk, the other half of the table word is given a distinct pattern with its own age bit set. This shows up a wrong half being selected, or a wrong half having its age cleared. The write and write-test runs separate the read-only and write-first codes from code 11. The base-register values are spaced apart, so a wrong base choice lands on a wrong address. One walk also injects a second request while busy, to show it is dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DECODE,
        ST_WBACK,
        ST_LOAD_EVEN,
        ST_LOAD_ODD,
        ST_REPORT
    } walk_state_e;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
    parameter int PA_W  = 20,
    parameter int IDX_W = 6
) (
    input  logic             user_i,
    input  logic             hi_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [PA_W-1:0]  base_ulo_i,
    input  logic [PA_W-1:0]  base_uhi_i,
    input  logic [PA_W-1:0]  base_ehi_i,
    input  logic [PA_W-1:0]  base_elo_i,
    output logic [PA_W-1:0]  tbl_addr_o
);
    logic [PA_W-1:0] base_sel;

    always_comb begin
        unique case ({user_i, hi_i})
            2'b10:   base_sel = base_ulo_i;
            2'b11:   base_sel = base_uhi_i;
            2'b01:   base_sel = base_ehi_i;
            default: base_sel = base_elo_i;
        endcase
    end

    assign tbl_addr_o = base_sel + {{(PA_W-IDX_W){1'b0}}, idx_i};
endmodule

// File: rtl/pgw_decode.sv
module pgw_decode #(
    parameter int HALF_W = 18,
    parameter int PAGE_W = 10
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                right_i,
    input  logic                wr_i,
    output logic                fault_o,
    output logic [1:0]          acc_field_o,
    output logic [HALF_W-1:0]   hw_even_o,
    output logic [2*HALF_W-1:0] wb_word_o
);
    localparam int AGE_POS   = HALF_W - 5;
    localparam int CACHE_POS = HALF_W - 6;
    localparam int HW_WR_POS = HALF_W - 4;
    localparam int HW_CA_POS = HALF_W - 5;

    logic [HALF_W-1:0] half_w [2];
    logic [HALF_W-1:0] ent;
    logic [1:0]        code;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic chosen;
        assign half_w[h] = word_i[h*HALF_W +: HALF_W];
        assign chosen    = (h == 0) ? right_i : !right_i;
        assign wb_word_o[h*HALF_W +: HALF_W] =
            half_w[h] & ~({{(HALF_W-1){1'b0}}, chosen} << AGE_POS);
    end

    assign ent  = right_i ? half_w[0] : half_w[1];
    assign code = ent[HALF_W-1 -: 2];

    always_comb begin
        fault_o     = (code == 2'b00) || ((code != 2'b11) && wr_i);
        acc_field_o = (code == 2'b11) ? 2'b00 : code;
        hw_even_o   = '0;
        hw_even_o[HALF_W-1]   = 1'b1;
        hw_even_o[HW_WR_POS]  = (code == 2'b11);
        hw_even_o[HW_CA_POS]  = ent[CACHE_POS];
        hw_even_o[PAGE_W:1]   = ent[PAGE_W-1:0];
    end

    logic unused_ent_bits;
    assign unused_ent_bits = ^{ent[HALF_W-3:AGE_POS], ent[CACHE_POS-1:PAGE_W]};
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int VA_W   = 18,
    parameter int PA_W   = 20,
    parameter int IDX_W  = 6,
    parameter int PAGE_W = 10,
    parameter int HALF_W = 18,
    localparam int WORD_W  = 2 * HALF_W,
    localparam int IDX_LSB = VA_W - 1 - IDX_W,
    localparam int SEL_BIT = IDX_LSB - 1,
    localparam int VPG_W   = VA_W - SEL_BIT + 1,
    localparam int FAIL_W  = VA_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_user,
    input  logic              req_write,
    input  logic              req_wtest,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   base_ulo,
    input  logic [PA_W-1:0]   base_uhi,
    input  logic [PA_W-1:0]   base_ehi,
    input  logic [PA_W-1:0]   base_elo,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tlb_load,
    output logic [VPG_W-1:0]  tlb_vpage,
    output logic [HALF_W-1:0] tlb_entry,
    output logic              done,
    output logic              fault,
    output logic [FAIL_W-1:0] fail_word
);
    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   vaddr;
        logic              user;
        logic              wr;
        logic [PA_W-1:0]   addr;
        logic [WORD_W-1:0] word;
        logic              flt;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [PA_W-1:0]   tbl_addr;
    logic              dec_fault;
    logic [1:0]        dec_acc;
    logic [HALF_W-1:0] hw_even;
    logic [WORD_W-1:0] wb_word;

    pgw_addr #(.PA_W(PA_W), .IDX_W(IDX_W)) u_addr (
        .user_i     (req_user),
        .hi_i       (req_vaddr[VA_W-1]),
        .idx_i      (req_vaddr[IDX_LSB +: IDX_W]),
        .base_ulo_i (base_ulo),
        .base_uhi_i (base_uhi),
        .base_ehi_i (base_ehi),
        .base_elo_i (base_elo),
        .tbl_addr_o (tbl_addr)
    );

    pgw_decode #(.HALF_W(HALF_W), .PAGE_W(PAGE_W)) u_decode (
        .word_i      (r_q.word),
        .right_i     (r_q.vaddr[SEL_BIT]),
        .wr_i        (r_q.wr),
        .fault_o     (dec_fault),
        .acc_field_o (dec_acc),
        .hw_even_o   (hw_even),
        .wb_word_o   (wb_word)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.user  = req_user;
                    r_d.wr    = req_write | req_wtest;
                    r_d.addr  = tbl_addr;
                    r_d.flt   = 1'b0;
                    r_d.st    = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    r_d.word = mem_rdata;
                    r_d.st   = ST_DECODE;
                end
            end
            ST_DECODE: begin
                r_d.flt = dec_fault;
                r_d.st  = dec_fault ? ST_REPORT : ST_WBACK;
            end
            ST_WBACK:     if (mem_ack) r_d.st = ST_LOAD_EVEN;
            ST_LOAD_EVEN: r_d.st = ST_LOAD_ODD;
            ST_LOAD_ODD:  r_d.st = ST_REPORT;
            ST_REPORT:    r_d.st = ST_IDLE;
            default:      r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic odd_phase;
    assign odd_phase = (r_q.st == ST_LOAD_ODD);

    assign busy      = (r_q.st != ST_IDLE);
    assign mem_req   = (r_q.st == ST_READ) || (r_q.st == ST_WBACK);
    assign mem_we    = (r_q.st == ST_WBACK);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = wb_word;
    assign tlb_load  = (r_q.st == ST_LOAD_EVEN) || odd_phase;
    assign tlb_vpage = {r_q.vaddr[VA_W-1:SEL_BIT], odd_phase};
    assign tlb_entry = hw_even | {{(HALF_W-1){1'b0}}, odd_phase};
    assign done      = (r_q.st == ST_REPORT);
    assign fault     = r_q.flt;
    assign fail_word = {r_q.user, r_q.wr, dec_acc, r_q.vaddr};

    // R9: request held steady until acknowledged
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8: the odd load directly follows the even load
    a_r8_odd_after_even: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_load && !tlb_vpage[0] |=> tlb_load && tlb_vpage[0]);

    // R8: successful completion comes right after the odd load
    a_r8_done_after_odd: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> $past(tlb_load) && $past(tlb_vpage[0]));

    // R7: every loaded translation carries the valid bit
    a_r7_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_load |-> tlb_entry[HALF_W-1]);

    // R3: a faulting walk loads nothing just before reporting
    a_r3_fault_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !$past(tlb_load) && !$past(mem_we));
endmodule

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0, req_wtest = 1'b0;
    logic [17:0] req_vaddr = '0;
    logic [19:0] base_ulo = 20'h10000, base_uhi = 20'h10040;
    logic [19:0] base_ehi = 20'h10080, base_elo = 20'h100C0;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [35:0] mem_wdata, mem_rdata;
    logic        tlb_load, done, fault;
    logic [8:0]  tlb_vpage;
    logic [17:0] tlb_entry;
    logic [21:0] fail_word;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pgw_walker u_pgw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
        .req_write(req_write), .req_wtest(req_wtest), .req_vaddr(req_vaddr),
        .base_ulo(base_ulo), .base_uhi(base_uhi), .base_ehi(base_ehi), .base_elo(base_elo),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tlb_load(tlb_load), .tlb_vpage(tlb_vpage), .tlb_entry(tlb_entry),
        .done(done), .fault(fault), .fail_word(fail_word)
    );

    // memory model: ack after a short wait, one cycle wide
    logic [35:0] mem [256];
    logic        set_we = 1'b0;
    logic [7:0]  set_a = '0;
    logic [35:0] set_d = '0;
    int          wait_cnt = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (set_we) mem[set_a] <= set_d;
        if (mem_req && !mem_ack) begin
            if (wait_cnt == 2) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                wait_cnt  <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // event monitor, sampled at the falling edge
    int          seq = 0;
    int          n_ld = 0, n_rd = 0, n_wr = 0, wr_seq = 0;
    logic [17:0] ld_ent [4];
    logic [8:0]  ld_vp  [4];
    int          ld_seq [4];
    logic [19:0] rd_addr, wr_addr;
    logic [35:0] wr_data;
    always @(negedge clk) begin
        seq <= seq + 1;
        if (tlb_load && n_ld < 4) begin
            ld_ent[n_ld] <= tlb_entry;
            ld_vp[n_ld]  <= tlb_vpage;
            ld_seq[n_ld] <= seq;
            n_ld <= n_ld + 1;
        end
        if (mem_req && mem_ack && !mem_we) begin
            n_rd <= n_rd + 1;
            rd_addr <= mem_addr;
        end
        if (mem_req && mem_ack && mem_we) begin
            n_wr <= n_wr + 1;
            wr_addr <= mem_addr;
            wr_data <= mem_wdata;
            wr_seq <= seq;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [35:0] d);
        @(negedge clk);
        set_we = 1'b1; set_a = a; set_d = d;
        @(negedge clk);
        set_we = 1'b0;
    endtask

    task automatic walk(input int code, input int user, input int hi, input int right,
                        input int op, input int idx, input int page, input int cache,
                        input int pgbit, input bit inject);
        logic [17:0] va, sel_half, oth_half;
        logic [19:0] exp_a;
        logic [35:0] word, exp_wb;
        logic [17:0] hw;
        logic [21:0] exp_fw;
        bit          wr, exp_fault;
        int          acc, guard;
        logic        f_got;
        logic [21:0] fw_got;
        va = {hi[0], idx[5:0], right[0], pgbit[0], 9'(idx * 7 + op)};
        case ({user[0], hi[0]})
            2'b10: exp_a = base_ulo;
            2'b11: exp_a = base_uhi;
            2'b01: exp_a = base_ehi;
            default: exp_a = base_elo;
        endcase
        exp_a = exp_a + 20'(idx);
        sel_half = {code[1:0], 2'b10, 1'b1, cache[0], 2'b01, page[9:0]};
        oth_half = {2'(3 - code), 2'b01, 1'b1, ~cache[0], 2'b10, ~page[9:0]};
        word = right ? {oth_half, sel_half} : {sel_half, oth_half};
        exp_wb = word;
        if (right) exp_wb[13] = 1'b0; else exp_wb[31] = 1'b0;
        wr = (op != 0);
        exp_fault = (code == 0) || (code != 3 && wr);
        acc = (code == 3) ? 0 : code;
        exp_fw = {user[0], wr, 2'(acc), va};
        hw = 18'(1 << 17) | 18'((code == 3) << 14) | 18'(cache[0] << 13) | 18'(page[9:0] << 1);
        poke(exp_a[7:0], word);
        n_ld = 0; n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_user = user[0]; req_vaddr = va;
        req_write = (op == 1); req_wtest = (op == 2);
        @(negedge clk);
        if (inject) begin
            req_user = ~user[0]; req_vaddr = ~va; req_write = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        guard = 0;
        f_got = 1'b0; fw_got = '0;
        while (guard < 60) begin
            @(negedge clk);
            req_valid = 1'b0;
            guard++;
            if (done) begin
                f_got = fault; fw_got = fail_word;
                break;
            end
        end
        chk(guard < 60, "R8 walk did not finish", guard, 0);
        repeat (4) @(negedge clk);
        chk(n_rd == 1 && rd_addr == exp_a, "R1 table read address", rd_addr, exp_a);
        chk(f_got == exp_fault, exp_fault ? "R3/R4 fault expected" : "R5 fault not expected",
            f_got, exp_fault);
        if (exp_fault) begin
            chk(fw_got == exp_fw, "R4 fail word", fw_got, exp_fw);
            chk(n_ld == 0, "R3 no translation load on fault", n_ld, 0);
            chk(n_wr == 0, "R3 no write-back on fault", n_wr, 0);
            chk(mem[exp_a[7:0]] == word, "R3 table word untouched", mem[exp_a[7:0]], word);
        end else begin
            chk(n_wr == 1 && wr_addr == exp_a, "R6 write-back address", wr_addr, exp_a);
            chk(wr_data == exp_wb, "R6 write-back age cleared (R2 half)", wr_data, exp_wb);
            chk(n_ld == 2, "R8 two loads", n_ld, 2);
            chk(wr_seq < ld_seq[0], "R6 write-back before loads", wr_seq, ld_seq[0]);
            chk(ld_seq[1] == ld_seq[0] + 1, "R8 loads consecutive", ld_seq[1], ld_seq[0] + 1);
            chk(ld_vp[0] == {va[17:10], 1'b0}, "R8 even vpage first", ld_vp[0], {va[17:10], 1'b0});
            chk(ld_vp[1] == {va[17:10], 1'b1}, "R8 odd vpage second", ld_vp[1], {va[17:10], 1'b1});
            chk(ld_ent[0] == hw, "R7 even entry (R2/R4/R5 fields)", ld_ent[0], hw);
            chk(ld_ent[1] == (hw | 18'd1), "R7 odd entry", ld_ent[1], hw | 18'd1);
        end
        if (inject) begin
            chk(!busy && n_rd == 1, "R10 request during walk ignored", n_rd, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy, "R11 busy after reset", busy, 0);
        chk(!mem_req, "R11 mem_req after reset", mem_req, 0);
        chk(!tlb_load && !done, "R11 load/done after reset", {tlb_load, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int code = 0; code < 4; code++)
            for (int user = 0; user < 2; user++)
                for (int hi = 0; hi < 2; hi++)
                    for (int right = 0; right < 2; right++)
                        for (int op = 0; op < 3; op++) begin
                            int idx;
                            idx = (code * 37 + user * 11 + hi * 5 + right * 3 + op * 13) % 64;
                            walk(code, user, hi, right, op, idx,
                                 (idx * 29 + code * 101 + op) % 1024, (idx ^ op) & 1,
                                 (code + op) & 1, 1'b0);
                        end
        walk(3, 1, 0, 1, 0, 63, 1023, 1, 1, 1'b1);
        walk(1, 0, 1, 0, 0, 0, 0, 0, 0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule